// File: doc/BRIEF.md
# Counter-Assisted Keystream Generator

This core produces a 128-bit keystream word on every clock once it has been keyed. Its internal state is 513 bits: eight 32-bit mixing variables, eight 32-bit counters and one carry bit. The whole state is updated in parallel in a single cycle. In each update the counters advance as one chained carry adder with fixed odd-pattern constants. Each lane then squares the sum of its variable and its fresh counter and folds the 64-bit square to 32 bits. The new variables are built from three neighbouring folded values, with rotations chosen by lane parity.

A one-cycle pulse on the start input samples the key, the IV and the IV-enable flag. It then runs setup:
1. Key expansion.
2. Four iterations.
3. A counter/variable cross XOR, with the IV words folded in during the same cycle when the flag is set.
4. When the flag is set, four more iterations.

After setup the core runs freely and flags every output word as valid. A new start pulse at any time abandons the current run and begins setup again. The keystream is meant to be XORed with data outside this block.

Top module: `streamCipherCore`

## Requirements
- R1: After reset `streamValid` is 0 and `coreReady` is 1 until the first start pulse.
- R2: Each iteration, counter j gains its constant plus a carry in: 0x4D34D34D for lanes 0, 3 and 6; 0xD34D34D3 for lanes 1, 4 and 7; 0x34D34D34 for lanes 2 and 5. Lane 0 takes the carry stored from the previous iteration. Lane j>0 takes the carry out of lane j-1 in the same iteration. The carry out of lane 7 is stored.
- R3: With u = x_j + c_j (mod 2^32, using the updated counter), g_j is the low half of u*u XOR the high half. For even j, the new x_j = g_j + rotl(g_{j-1},16) + rotl(g_{j-2},16). For odd j, the new x_j = g_j + rotl(g_{j-1},8) + g_{j-2}. Lane indices are taken mod 8.
- R4: Key expansion uses 16-bit key words k0 (bits 15:0) to k7 (bits 127:112). For even j, x_j = {k(j+1),k(j)} and c_j = {k(j+4),k(j+5)}. For odd j, x_j = {k(j+5),k(j+4)} and c_j = {k(j),k(j+1)}. Indices are mod 8, the first word in each pair is the upper half, and the carry is cleared.
- R5: After four iterations, each c_j is replaced by c_j XOR x_{(j+4) mod 8}. With the IV flag low, the first valid word appears 6 clock edges after the edge that samples start.
- R6: With the IV flag set, the IV is split into 16-bit words iv0 (bits 15:0) to iv3. In the cross-XOR cycle, c0 and c4 are also XORed with {iv1,iv0}, c1 and c5 with {iv3,iv1}, c2 and c6 with {iv3,iv2}, and c3 and c7 with {iv2,iv0}. Four more iterations follow, and the first valid word appears 10 edges after the start edge.
- R7: Each running cycle performs one iteration and outputs {s7,...,s0}, where s0 is in bits 15:0, taken from the state after that iteration. The halves are s0=x0L^x5H, s1=x0H^x3L, s2=x2L^x7H, s3=x2H^x5L, s4=x4L^x1H, s5=x4H^x7L, s6=x6L^x3H and s7=x6H^x1L. `streamValid` then stays high on every cycle until the next start.
- R8: A start pulse, even in mid-setup or mid-run, drops `streamValid` and `coreReady` at the next edge and restarts setup from the newly sampled key.
- R9: When the IV flag sampled at start is low, the IV value has no effect on the keystream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start pulse; samples key, IV and IV flag |
| ivEnable | input | 1 | Selects IV mixing for this run |
| keyIn | input | 128 | Key |
| ivIn | input | 64 | Initial vector |
| keyStream | output | 128 | Keystream word |
| streamValid | output | 1 | Keystream word is valid |
| coreReady | output | 1 | High when idle or running, low during setup |

## Verification
The bench sweeps keys of several kinds: zero, all ones, alternating patterns, and a single set bit walked across every 16-bit key word. The single-bit keys show whether each key word reaches the lane the expansion assigns it. The dense keys drive the counter carry chain through long carry runs. IV runs repeat one key with a single IV bit walked through each IV word, which exposes a wrong IV pairing. Runs with the flag low but different IVs must match, which shows the IV is ignored. Restarts issued in mid-setup and in mid-run, with the latency counted from the restart, show that the old run is fully abandoned.

// File: rtl/streamPkg.sv
package streamPkg;
  localparam int WORD  = 32;
  localparam int HALF  = WORD / 2;
  localparam int LANES = 8;
  localparam int KEYW  = LANES * HALF;
  localparam int IVW   = KEYW / 2;

  typedef struct packed {
    logic loadKey;
    logic step;
    logic mixCtr;
    logic mixIv;
    logic runStep;
  } ctrlT;

  function automatic logic [WORD-1:0] laneConst(input int j);
    case (j % 3)
      0:       return 32'h4D34D34D;
      1:       return 32'hD34D34D3;
      default: return 32'h34D34D34;
    endcase
  endfunction

  function automatic logic [WORD-1:0] rotl(input logic [WORD-1:0] v, input int n);
    return (v << n) | (v >> (WORD - n));
  endfunction
endpackage

// File: rtl/counterChain.sv
module counterChain
  import streamPkg::*;
#(
  parameter int N = LANES
) (
  input  logic [N-1:0][WORD-1:0] ctrIn,
  input  logic                   carryIn,
  output logic [N-1:0][WORD-1:0] ctrOut,
  output logic                   carryOut
);
  logic [N:0] carry;
  assign carry[0] = carryIn;

  for (genvar j = 0; j < N; j++) begin : gLane
    logic [WORD:0] sum;
    assign sum = {1'b0, ctrIn[j]} + {1'b0, laneConst(j)} + {{WORD{1'b0}}, carry[j]};
    assign ctrOut[j]  = sum[WORD-1:0];
    assign carry[j+1] = sum[WORD];
  end

  assign carryOut = carry[N];
endmodule

// File: rtl/mixLane.sv
module mixLane
  import streamPkg::*;
(
  input  logic [WORD-1:0] varIn,
  input  logic [WORD-1:0] ctrIn,
  output logic [WORD-1:0] gOut
);
  logic [WORD-1:0]   u;
  logic [2*WORD-1:0] sq;
  assign u    = varIn + ctrIn;
  assign sq   = (2*WORD)'(u) * (2*WORD)'(u);
  assign gOut = sq[WORD-1:0] ^ sq[2*WORD-1:WORD];
endmodule

// File: rtl/cipherCtrl.sv
module cipherCtrl
  import streamPkg::*;
#(
  parameter int SETUP_ITERS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic startIn,
  input  logic ivEnable,
  output ctrlT ctrl,
  output logic ready
);
  localparam int CW = (SETUP_ITERS > 1) ? $clog2(SETUP_ITERS) : 1;

  typedef enum logic [2:0] {IDLE, KEYRUN, MIX, IVRUN, RUN} stateT;
  stateT   state;
  logic [CW-1:0] iterCnt;
  logic    ivFlag;
  logic    lastIter;

  assign lastIter = (iterCnt == CW'(SETUP_ITERS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= IDLE;
      iterCnt <= '0;
      ivFlag  <= 1'b0;
    end else if (startIn) begin
      state   <= KEYRUN;
      iterCnt <= '0;
      ivFlag  <= ivEnable;
    end else begin
      case (state)
        KEYRUN, IVRUN: begin
          if (lastIter) begin
            iterCnt <= '0;
            state   <= (state == KEYRUN) ? MIX : RUN;
          end else begin
            iterCnt <= iterCnt + 1'b1;
          end
        end
        MIX:     state <= ivFlag ? IVRUN : RUN;
        default: state <= state;
      endcase
    end
  end

  always_comb begin
    ctrl.loadKey = startIn;
    ctrl.step    = !startIn && (state == KEYRUN || state == IVRUN || state == RUN);
    ctrl.mixCtr  = !startIn && (state == MIX);
    ctrl.mixIv   = !startIn && (state == MIX) && ivFlag;
    ctrl.runStep = !startIn && (state == RUN);
  end

  assign ready = (state == IDLE) || (state == RUN);
endmodule

// File: rtl/cipherDatapath.sv
module cipherDatapath
  import streamPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctrlT            ctrl,
  input  logic [KEYW-1:0] keyIn,
  input  logic [IVW-1:0]  ivIn,
  output logic [KEYW-1:0] keyStream,
  output logic            streamValid
);
  logic [LANES-1:0][WORD-1:0] xState, cState, cNext, gVal, xNext;
  logic [LANES-1:0][WORD-1:0] xInit, cInit, ivWord;
  logic [LANES-1:0][HALF-1:0] kw;
  logic [3:0][HALF-1:0]       ivw;
  logic [IVW-1:0]             ivHeld;
  logic                       carry, carryNext;
  logic [KEYW-1:0]            extract;

  assign kw  = keyIn;
  assign ivw = ivHeld;

  counterChain #(.N(LANES)) uChain (
    .ctrIn(cState), .carryIn(carry), .ctrOut(cNext), .carryOut(carryNext)
  );

  for (genvar j = 0; j < LANES; j++) begin : gLane
    mixLane uMix (.varIn(xState[j]), .ctrIn(cNext[j]), .gOut(gVal[j]));

    if (j % 2 == 0) begin : gEven
      assign xNext[j] = gVal[j] + rotl(gVal[(j+7)%8], 16) + rotl(gVal[(j+6)%8], 16);
      assign xInit[j] = {kw[(j+1)%8], kw[j]};
      assign cInit[j] = {kw[(j+4)%8], kw[(j+5)%8]};
    end else begin : gOdd
      assign xNext[j] = gVal[j] + rotl(gVal[(j+7)%8], 8) + gVal[(j+6)%8];
      assign xInit[j] = {kw[(j+5)%8], kw[(j+4)%8]};
      assign cInit[j] = {kw[j], kw[(j+1)%8]};
    end

    if (j % 4 == 0) begin : gIv0
      assign ivWord[j] = {ivw[1], ivw[0]};
    end else if (j % 4 == 1) begin : gIv1
      assign ivWord[j] = {ivw[3], ivw[1]};
    end else if (j % 4 == 2) begin : gIv2
      assign ivWord[j] = {ivw[3], ivw[2]};
    end else begin : gIv3
      assign ivWord[j] = {ivw[2], ivw[0]};
    end
  end

  for (genvar h = 0; h < LANES / 2; h++) begin : gOut
    localparam int XA = 2 * h;
    assign extract[(2*h)*HALF +: HALF] =
      xNext[XA][HALF-1:0] ^ xNext[(XA+5)%8][WORD-1:HALF];
    assign extract[(2*h+1)*HALF +: HALF] =
      xNext[XA][WORD-1:HALF] ^ xNext[(XA+3)%8][HALF-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xState      <= '0;
      cState      <= '0;
      carry       <= 1'b0;
      ivHeld      <= '0;
      keyStream   <= '0;
      streamValid <= 1'b0;
    end else begin
      if (ctrl.loadKey) begin
        xState      <= xInit;
        cState      <= cInit;
        carry       <= 1'b0;
        ivHeld      <= ivIn;
        streamValid <= 1'b0;
      end else if (ctrl.step) begin
        xState <= xNext;
        cState <= cNext;
        carry  <= carryNext;
      end else if (ctrl.mixCtr) begin
        for (int j = 0; j < LANES; j++) begin
          cState[j] <= cState[j] ^ xState[(j+4)%8] ^ (ctrl.mixIv ? ivWord[j] : '0);
        end
      end
      if (ctrl.runStep) begin
        keyStream   <= extract;
        streamValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/streamCipherCore.sv
module streamCipherCore
  import streamPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         ivEnable,
  input  logic [127:0] keyIn,
  input  logic [63:0]  ivIn,
  output logic [127:0] keyStream,
  output logic         streamValid,
  output logic         coreReady
);
  ctrlT ctrl;

  cipherCtrl #(.SETUP_ITERS(4)) uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .ivEnable(ivEnable),
    .ctrl(ctrl), .ready(coreReady)
  );

  cipherDatapath uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .keyIn(keyIn), .ivIn(ivIn),
    .keyStream(keyStream), .streamValid(streamValid)
  );
endmodule

// File: rtl/cipherChecker.sv
module cipherChecker (
  input logic clk,
  input logic rstN,
  input logic startIn,
  input logic streamValid,
  input logic coreReady
);
  // R7: a valid word is only produced while running
  assert_valid_needs_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    streamValid |-> coreReady);
  // R7: once valid, stays valid until a restart
  assert_valid_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (streamValid && !startIn) |=> streamValid);
  // R8: start drops valid
  assert_start_clears_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> !streamValid);
  // R8: start enters setup
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> !coreReady);
  // R5: no word leaves during setup
  assert_setup_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!coreReady && !startIn) |=> !streamValid);
endmodule

bind streamCipherCore cipherChecker uChk (
  .clk(clk), .rstN(rstN), .startIn(startIn),
  .streamValid(streamValid), .coreReady(coreReady)
);

// File: tb/sim_streamCipherCore.sv
module sim_streamCipherCore;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rstN, startIn, ivEnable;
  logic [127:0] keyIn, keyStream;
  logic [63:0]  ivIn;
  logic         streamValid, coreReady;

  streamCipherCore u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .ivEnable(ivEnable),
    .keyIn(keyIn), .ivIn(ivIn), .keyStream(keyStream),
    .streamValid(streamValid), .coreReady(coreReady)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] rx [8];
  logic [31:0] rc [8];
  logic        rcar;

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [31:0] cst(input int j);
    if (j == 0 || j == 3 || j == 6) return 32'h4D34D34D;
    if (j == 1 || j == 4 || j == 7) return 32'hD34D34D3;
    return 32'h34D34D34;
  endfunction

  task automatic refIter();
    logic [32:0] s;
    logic [63:0] q;
    logic [31:0] g [8];
    logic        car;
    car = rcar;
    for (int j = 0; j < 8; j++) begin
      s = {1'b0, rc[j]} + {1'b0, cst(j)} + {32'd0, car};
      rc[j] = s[31:0];
      car = s[32];
    end
    rcar = car;
    for (int j = 0; j < 8; j++) begin
      q = {32'd0, rx[j] + rc[j]} * {32'd0, rx[j] + rc[j]};
      g[j] = q[31:0] ^ q[63:32];
    end
    for (int j = 0; j < 8; j++) begin
      if (j % 2 == 0) rx[j] = g[j] + rl(g[(j+7)%8], 16) + rl(g[(j+6)%8], 16);
      else            rx[j] = g[j] + rl(g[(j+7)%8], 8) + g[(j+6)%8];
    end
  endtask

  task automatic refSetup(input logic [127:0] key, input logic [63:0] iv, input bit en);
    logic [15:0] k [8];
    logic [15:0] v [4];
    logic [31:0] t [8];
    for (int i = 0; i < 8; i++) k[i] = key[16*i +: 16];
    for (int i = 0; i < 4; i++) v[i] = iv[16*i +: 16];
    for (int j = 0; j < 8; j++) begin
      if (j % 2 == 0) begin
        rx[j] = {k[(j+1)%8], k[j]};
        rc[j] = {k[(j+4)%8], k[(j+5)%8]};
      end else begin
        rx[j] = {k[(j+5)%8], k[(j+4)%8]};
        rc[j] = {k[j], k[(j+1)%8]};
      end
    end
    rcar = 1'b0;
    for (int i = 0; i < 4; i++) refIter();
    for (int j = 0; j < 8; j++) t[j] = rc[j] ^ rx[(j+4)%8];
    for (int j = 0; j < 8; j++) rc[j] = t[j];
    if (en) begin
      rc[0] ^= {v[1], v[0]}; rc[4] ^= {v[1], v[0]};
      rc[1] ^= {v[3], v[1]}; rc[5] ^= {v[3], v[1]};
      rc[2] ^= {v[3], v[2]}; rc[6] ^= {v[3], v[2]};
      rc[3] ^= {v[2], v[0]}; rc[7] ^= {v[2], v[0]};
      for (int i = 0; i < 4; i++) refIter();
    end
  endtask

  function automatic logic [127:0] refOut();
    logic [15:0] s [8];
    s[0] = rx[0][15:0]  ^ rx[5][31:16];
    s[1] = rx[0][31:16] ^ rx[3][15:0];
    s[2] = rx[2][15:0]  ^ rx[7][31:16];
    s[3] = rx[2][31:16] ^ rx[5][15:0];
    s[4] = rx[4][15:0]  ^ rx[1][31:16];
    s[5] = rx[4][31:16] ^ rx[7][15:0];
    s[6] = rx[6][15:0]  ^ rx[3][31:16];
    s[7] = rx[6][31:16] ^ rx[1][15:0];
    return {s[7], s[6], s[5], s[4], s[3], s[2], s[1], s[0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runCase(input logic [127:0] key, input logic [63:0] iv,
                         input bit en, input int nWords, input string tag);
    int cnt;
    logic [127:0] exp;
    @(negedge clk);
    keyIn = key; ivIn = iv; ivEnable = en; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0; ivEnable = ~en; ivIn = ~iv; keyIn = ~key;
    check(!streamValid && !coreReady, "R8", {tag, " valid/ready after start"},
          {126'd0, streamValid, coreReady}, 128'd0);
    cnt = 0;
    while (!streamValid && cnt < 40) begin
      @(negedge clk);
      cnt++;
      if (cnt == 3)
        check(!coreReady, "R8", {tag, " ready low in setup"}, {127'd0, coreReady}, 128'd0);
    end
    check(cnt == (en ? 10 : 6), en ? "R6" : "R5", {tag, " first word latency"},
          128'(cnt), en ? 128'd10 : 128'd6);
    refSetup(key, iv, en);
    for (int w = 0; w < nWords; w++) begin
      refIter();
      exp = refOut();
      check(streamValid && keyStream == exp, "R7", {tag, " keystream word (R2 R3 R4)"},
            keyStream, exp);
      @(negedge clk);
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; startIn = 1'b0; ivEnable = 1'b0; keyIn = '0; ivIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!streamValid && coreReady, "R1", "reset state",
          {126'd0, streamValid, coreReady}, 128'd1);
    repeat (3) @(negedge clk);
    check(!streamValid && coreReady, "R1", "idle before start",
          {126'd0, streamValid, coreReady}, 128'd1);

    runCase(128'd0, 64'd0, 1'b0, 6, "zero key");
    runCase({128{1'b1}}, 64'd0, 1'b0, 6, "ones key");
    runCase({32{4'hA}}, 64'd0, 1'b0, 4, "alt key");
    runCase(128'h0123456789ABCDEFFEDCBA9876543210, 64'd0, 1'b0, 4, "mixed key");
    for (int b = 0; b < 128; b += 5)
      runCase(128'd1 << b, 64'd0, 1'b0, 2, "walk key R4");

    runCase(128'd0, 64'd0, 1'b1, 4, "zero iv R6");
    for (int b = 0; b < 64; b += 3)
      runCase(128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0, 64'd1 << b, 1'b1, 2, "walk iv R6");

    runCase(128'h00112233445566778899AABBCCDDEEFF, 64'h1234567890ABCDEF, 1'b0, 3, "iv ignored A R9");
    runCase(128'h00112233445566778899AABBCCDDEEFF, 64'hFEDCBA0987654321, 1'b0, 3, "iv ignored B R9");

    @(negedge clk);
    keyIn = {128{1'b1}}; ivEnable = 1'b1; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    repeat (3) @(negedge clk);
    runCase(128'hDEADBEEF00000000CAFEF00D12345678, 64'h55AA, 1'b1, 4, "abort setup R8");
    repeat (5) @(negedge clk);
    runCase(128'h1, 64'd0, 1'b0, 4, "abort run R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule